// File: doc/BRIEF.md
# DMA Request Line Router

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. Each request line owns one mapping register. The register holds a routing-enable bit and a 5-bit channel number. While the routing is enabled, the line's request is forwarded to the chosen channel, and that channel's acknowledge is returned to the line. Several lines may share one channel: their requests are OR-ed, and the channel acknowledge goes back to every one of them.

Software programs the block through a small register port with single-cycle writes and reads that return data one cycle later. The mapping registers sit in two address windows. The lower request lines are in the low window and the rest are in a high window, so the line count can grow past 64 without moving existing addresses. Two channel-indexed registers are also reachable through the port:
- a writable per-channel unaligned-access enable, driven out to the channels;
- a read-only view of the channels' interrupt lines.

Top module: `dreq_router`

## Requirements
- R1: Request line n below 64 has its mapping word at byte address 0x0100 + 4*n.
- R2: Request line n of 64 or above has its mapping word at byte address 0x1100 + 4*(n-64).
- R3: A mapping write keeps bit 7 (routing enable) and bits 4:0 (channel number). A read returns those bits and zeros everywhere else. Read data and the read-valid flag appear in the cycle after the read strobe.
- R4: A line whose routing-enable bit is clear never raises any channel request.
- R5: A line with routing enabled drives the request of the channel named in bits 4:0, in the same cycle, with no register on the path.
- R6: When several enabled lines name the same channel, that channel's request is the OR of their requests, and the channel's acknowledge is returned to all of them.
- R7: A line's acknowledge is high only when its routing is enabled and its chosen channel's acknowledge is high.
- R8: Writing zero to a mapping word removes that line's routing. Mapping state changes only on a write.
- R9: The word at 0x00A0 holds one bit per channel (bit c for channel c). It drives `ch_unaligned` and reads back as written.
- R10: The word at 0x00F0 reads the current `ch_irq` inputs (bit c for channel c). Writes to it have no effect.
- R11: After reset, every mapping word, the unaligned-enable word, every channel request and every line acknowledge are zero.
- R12: Accesses that decode to nothing write nothing and read zero. This covers addresses outside the windows and the two words, addresses that are not word-aligned, and lines beyond the configured line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| line_req | input | NUM_LINES | Peripheral request lines |
| line_ack | output | NUM_LINES | Acknowledge back to each line |
| ch_req | output | NUM_CH | Request to each DMA channel |
| ch_ack | input | NUM_CH | Acknowledge from each DMA channel |
| ch_unaligned | output | NUM_CH | Per-channel unaligned-address enable |
| ch_irq | input | NUM_CH | Per-channel interrupt pending, read-only view |

## Verification
Some rules are checked by the assertions on every cycle:
- the read-valid flag follows the read strobe by one cycle;
- mapping and unaligned-enable state hold steady whenever no write is present;
- a channel request never appears while no line requests;
- a line acknowledge never appears without some channel acknowledge.

Other behaviour can only be shown by the bench's scenarios. This includes the two-window address decode, the bits kept on readback, and routing to the correct channel. It also covers OR-ing on a shared channel with its acknowledge fan-out, removal of a route by writing zero, and the writes that must be dropped.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

   // width of the channel-number field inside a mapping word
   localparam int unsigned CHAN_FW = 5;
   // bit position of the routing-enable flag inside a mapping word
   localparam int unsigned VLD_BIT = 7;

   typedef struct packed {
      logic               vld;
      logic [CHAN_FW-1:0] chan;
   } route_t;

   function automatic logic [7:0] route_byte(input route_t r);
      route_byte = {r.vld, 2'b00, r.chan};
   endfunction

   function automatic route_t byte_route(input logic [7:0] b);
      route_t r;
      r.vld  = b[VLD_BIT];
      r.chan = b[CHAN_FW-1:0];
      return r;
   endfunction

endpackage

// File: rtl/dreq_router_decode.sv
module dreq_router_decode
   import dreq_router_pkg::*;
#(
   parameter int unsigned     NUM_LINES = 80,
   parameter int unsigned     ADDR_W    = 13,
   parameter logic [ADDR_W-1:0] WIN0_BASE = 13'h0100,
   parameter logic [ADDR_W-1:0] WIN1_BASE = 13'h1100,
   parameter logic [ADDR_W-1:0] ALIGN_OFS = 13'h00A0,
   parameter logic [ADDR_W-1:0] IRQ_OFS   = 13'h00F0,
   localparam int unsigned    LIDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_line,
   output logic [LIDX_W-1:0] line_idx,
   output logic              hit_align,
   output logic              hit_irq
);

   // each window spans 64 words = 256 bytes
   localparam int unsigned WIN_LSB = 8;

   logic       in_win0;
   logic       in_win1;
   logic [6:0] idx_full;

   if (ADDR_W <= WIN_LSB) begin : g_bad_addr_w
      $error("dreq_router_decode: ADDR_W must exceed 8");
   end
   if (WIN0_BASE[WIN_LSB-1:0] != '0 || WIN1_BASE[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("dreq_router_decode: window bases must be 256-byte aligned");
   end
   if (NUM_LINES < 1 || NUM_LINES > 128) begin : g_bad_lines
      $error("dreq_router_decode: NUM_LINES must lie in 1..128");
   end

   assign in_win0 = (addr[ADDR_W-1:WIN_LSB] == WIN0_BASE[ADDR_W-1:WIN_LSB]);

   // the high window exists only when more than 64 lines are configured
   if (NUM_LINES > 64) begin : g_win1
      assign in_win1 = (addr[ADDR_W-1:WIN_LSB] == WIN1_BASE[ADDR_W-1:WIN_LSB]);
   end else begin : g_no_win1
      assign in_win1 = 1'b0;
   end

   assign idx_full  = {in_win1, addr[WIN_LSB-1:2]};
   assign hit_line  = (in_win0 | in_win1) && (addr[1:0] == 2'b00)
                      && (int'(idx_full) < int'(NUM_LINES));
   assign line_idx  = LIDX_W'(idx_full);
   assign hit_align = (addr == ALIGN_OFS);
   assign hit_irq   = (addr == IRQ_OFS);

endmodule

// File: rtl/dreq_router_regs.sv
module dreq_router_regs
   import dreq_router_pkg::*;
#(
   parameter int unsigned NUM_LINES = 80,
   parameter int unsigned NUM_CH    = 32,
   parameter int unsigned DATA_W    = 32,
   localparam int unsigned LIDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic                     rd,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     hit_line,
   input  logic [LIDX_W-1:0]        line_idx,
   input  logic                     hit_align,
   input  logic                     hit_irq,
   input  logic [NUM_CH-1:0]        ch_irq,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rvalid,
   output route_t [NUM_LINES-1:0]   route_o,
   output logic [NUM_CH-1:0]        align_o
);

   route_t [NUM_LINES-1:0] route_q;
   logic [NUM_CH-1:0]      align_q;
   logic [DATA_W-1:0]      rd_mux;
   logic [DATA_W-1:0]      rdata_q;
   logic                   rvalid_q;

   if (DATA_W < 8 || DATA_W < NUM_CH) begin : g_bad_data_w
      $error("dreq_router_regs: DATA_W too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else if (wr && hit_line) begin
         route_q[line_idx] <= byte_route(wdata[7:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         align_q <= '0;
      end else if (wr && hit_align) begin
         align_q <= wdata[NUM_CH-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (hit_line) begin
         rd_mux[7:0] = route_byte(route_q[line_idx]);
      end else if (hit_align) begin
         rd_mux[NUM_CH-1:0] = align_q;
      end else if (hit_irq) begin
         rd_mux[NUM_CH-1:0] = ch_irq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd;
         rdata_q  <= rd ? rd_mux : '0;
      end
   end

   assign rdata   = rdata_q;
   assign rvalid  = rvalid_q;
   assign route_o = route_q;
   assign align_o = align_q;

   // R3: read data is flagged exactly one cycle after the strobe
   p_rvalid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rvalid);
   p_rvalid_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rvalid);
   // R8: routing state only moves on a write
   p_route_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(route_o));
   // R9: unaligned enables only move on a write
   p_align_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(align_o));

endmodule

// File: rtl/dreq_router_fwd.sv
module dreq_router_fwd
   import dreq_router_pkg::*;
#(
   parameter int unsigned NUM_LINES = 80,
   parameter int unsigned NUM_CH    = 32
) (
   input  route_t [NUM_LINES-1:0] route,
   input  logic [NUM_LINES-1:0]   line_req,
   output logic [NUM_CH-1:0]      ch_req
);

   if (NUM_CH < 1 || NUM_CH > (1 << CHAN_FW)) begin : g_bad_ch
      $error("dreq_router_fwd: NUM_CH must lie in 1..32");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [NUM_LINES-1:0] sel;
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         assign sel[l] = route[l].vld && (route[l].chan == CHAN_FW'(c)) && line_req[l];
      end
      assign ch_req[c] = |sel;
   end

endmodule

// File: rtl/dreq_router_ack.sv
module dreq_router_ack
   import dreq_router_pkg::*;
#(
   parameter int unsigned NUM_LINES = 80,
   parameter int unsigned NUM_CH    = 32
) (
   input  route_t [NUM_LINES-1:0] route,
   input  logic [NUM_CH-1:0]      ch_ack,
   output logic [NUM_LINES-1:0]   line_ack
);

   localparam int unsigned FULL_CH = 1 << CHAN_FW;

   logic [FULL_CH-1:0] ack_pad;

   // channel numbers beyond NUM_CH see a zero acknowledge
   if (NUM_CH < FULL_CH) begin : g_pad
      assign ack_pad = {{(FULL_CH-NUM_CH){1'b0}}, ch_ack};
   end else begin : g_full
      assign ack_pad = ch_ack;
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign line_ack[l] = route[l].vld && ack_pad[route[l].chan];
   end

endmodule

// File: rtl/dreq_router.sv
module dreq_router
   import dreq_router_pkg::*;
#(
   parameter int unsigned       NUM_LINES = 80,
   parameter int unsigned       NUM_CH    = 32,
   parameter int unsigned       ADDR_W    = 13,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [ADDR_W-1:0] WIN0_BASE = 13'h0100,
   parameter logic [ADDR_W-1:0] WIN1_BASE = 13'h1100,
   parameter logic [ADDR_W-1:0] ALIGN_OFS = 13'h00A0,
   parameter logic [ADDR_W-1:0] IRQ_OFS   = 13'h00F0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 reg_rvalid,
   input  logic [NUM_LINES-1:0] line_req,
   output logic [NUM_LINES-1:0] line_ack,
   output logic [NUM_CH-1:0]    ch_req,
   input  logic [NUM_CH-1:0]    ch_ack,
   output logic [NUM_CH-1:0]    ch_unaligned,
   input  logic [NUM_CH-1:0]    ch_irq
);

   localparam int unsigned LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   logic                   hit_line;
   logic [LIDX_W-1:0]      line_idx;
   logic                   hit_align;
   logic                   hit_irq;
   route_t [NUM_LINES-1:0] route;

   dreq_router_decode #(
      .NUM_LINES (NUM_LINES),
      .ADDR_W    (ADDR_W),
      .WIN0_BASE (WIN0_BASE),
      .WIN1_BASE (WIN1_BASE),
      .ALIGN_OFS (ALIGN_OFS),
      .IRQ_OFS   (IRQ_OFS)
   ) u_decode (
      .addr      (reg_addr),
      .hit_line  (hit_line),
      .line_idx  (line_idx),
      .hit_align (hit_align),
      .hit_irq   (hit_irq)
   );

   dreq_router_regs #(
      .NUM_LINES (NUM_LINES),
      .NUM_CH    (NUM_CH),
      .DATA_W    (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .rd        (reg_rd),
      .wdata     (reg_wdata),
      .hit_line  (hit_line),
      .line_idx  (line_idx),
      .hit_align (hit_align),
      .hit_irq   (hit_irq),
      .ch_irq    (ch_irq),
      .rdata     (reg_rdata),
      .rvalid    (reg_rvalid),
      .route_o   (route),
      .align_o   (ch_unaligned)
   );

   dreq_router_fwd #(
      .NUM_LINES (NUM_LINES),
      .NUM_CH    (NUM_CH)
   ) u_fwd (
      .route    (route),
      .line_req (line_req),
      .ch_req   (ch_req)
   );

   dreq_router_ack #(
      .NUM_LINES (NUM_LINES),
      .NUM_CH    (NUM_CH)
   ) u_ack (
      .route    (route),
      .ch_ack   (ch_ack),
      .line_ack (line_ack)
   );

   // R4: no channel request without some line requesting
   p_req_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_req != '0) |-> (line_req != '0));
   // R7: no line acknowledge without some channel acknowledging
   p_ack_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ack != '0) |-> (ch_ack != '0));

endmodule

// File: tb/dreq_router_tb_top.sv
`timescale 1ns/1ps
module dreq_router_tb_top;

   localparam int NL = 80;
   localparam int NC = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [12:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          reg_rvalid;
   logic [NL-1:0] line_req = '0;
   logic [NL-1:0] line_ack;
   logic [NC-1:0] ch_req;
   logic [NC-1:0] ch_ack = '0;
   logic [NC-1:0] ch_unaligned;
   logic [NC-1:0] ch_irq = '0;

   int compared = 0;
   int mismatched = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   dreq_router dut_i (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .reg_rvalid (reg_rvalid),
      .line_req (line_req), .line_ack (line_ack),
      .ch_req (ch_req), .ch_ack (ch_ack),
      .ch_unaligned (ch_unaligned), .ch_irq (ch_irq)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: issues a read and pushes the expected value to the scoreboard
   task automatic rd_reg(input logic [12:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // monitor: pops and compares as read data appears
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         if (exp_q.size() == 0) begin
            compared++; mismatched++;
            $display("FAIL R3 unexpected read data actual=%0h expected=none", reg_rdata);
         end else begin
            chk(tag_q.pop_front(), 128'(reg_rdata), 128'(exp_q.pop_front()));
         end
      end
   end

   task automatic settle();
      @(negedge clk); #1;
   endtask

   function automatic logic [NL-1:0] lbit(input int n);
      return NL'(1) << n;
   endfunction

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL R3 reads left unanswered actual=%0d expected=0", exp_q.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      line_req = '1; ch_ack = '1;
      settle();
      chk("R11 no channel request after reset", 128'(ch_req), 128'(0));
      chk("R11 no line ack after reset", 128'(line_ack), 128'(0));
      chk("R11 unaligned enables clear", 128'(ch_unaligned), 128'(0));
      rd_reg(13'h0100, 32'h0, "R11 line 0 map clear");
      rd_reg(13'h113C, 32'h0, "R11 line 79 map clear");
      rd_reg(13'h00A0, 32'h0, "R11 unaligned word clear");
      line_req = '0; ch_ack = '0;

      // R1 R3 R5 R7: line 5 to channel 3, junk bits dropped
      wr_reg(13'h0114, 32'hFFFF_FF83);
      rd_reg(13'h0114, 32'h0000_0083, "R1 R3 line 5 readback");
      line_req = lbit(5);
      settle();
      chk("R5 line 5 drives channel 3", 128'(ch_req), 128'(32'h8));
      ch_ack = 32'h8;
      settle();
      chk("R7 channel 3 ack to line 5", 128'(line_ack), 128'(lbit(5)));
      ch_ack = 32'h4;
      settle();
      chk("R7 other channel ack ignored", 128'(line_ack), 128'(0));
      line_req = '0; ch_ack = '0;

      // R2: high window
      wr_reg(13'h1100, 32'h0000_008A);
      wr_reg(13'h113C, 32'h0000_009F);
      rd_reg(13'h1100, 32'h0000_008A, "R2 line 64 readback");
      rd_reg(13'h113C, 32'h0000_009F, "R2 line 79 readback");
      line_req = lbit(79);
      settle();
      chk("R2 R5 line 79 drives channel 31", 128'(ch_req), 128'(32'h8000_0000));

      // R6: lines 63 and 64 share channel 10
      wr_reg(13'h01FC, 32'h0000_008A);
      line_req = lbit(63) | lbit(64);
      settle();
      chk("R6 shared channel 10 request", 128'(ch_req), 128'(32'h400));
      line_req = lbit(63);
      settle();
      chk("R6 one sharer still requests", 128'(ch_req), 128'(32'h400));
      ch_ack = 32'h400;
      settle();
      chk("R6 ack fans out to both sharers", 128'(line_ack), 128'(lbit(63) | lbit(64)));
      line_req = '0; ch_ack = '0;

      // R4: line 0 names channel 7 but routing disabled
      wr_reg(13'h0100, 32'h0000_0007);
      rd_reg(13'h0100, 32'h0000_0007, "R4 disabled map readback");
      line_req = lbit(0);
      settle();
      chk("R4 disabled line raises nothing", 128'(ch_req), 128'(0));
      ch_ack = 32'h80;
      settle();
      chk("R4 disabled line gets no ack", 128'(line_ack), 128'(0));
      line_req = '0; ch_ack = '0;

      // R8: zero write removes route of line 5
      wr_reg(13'h0114, 32'h0);
      rd_reg(13'h0114, 32'h0, "R8 cleared map readback");
      line_req = lbit(5);
      settle();
      chk("R8 cleared line raises nothing", 128'(ch_req), 128'(0));
      line_req = '0;

      // R9: unaligned enables
      wr_reg(13'h00A0, 32'h8000_0001);
      settle();
      chk("R9 unaligned outputs", 128'(ch_unaligned), 128'(32'h8000_0001));
      rd_reg(13'h00A0, 32'h8000_0001, "R9 unaligned readback");

      // R10: interrupt view, write ignored
      ch_irq = 32'h1234_5678;
      rd_reg(13'h00F0, 32'h1234_5678, "R10 irq view");
      wr_reg(13'h00F0, 32'hFFFF_FFFF);
      ch_irq = 32'h0000_00F0;
      rd_reg(13'h00F0, 32'h0000_00F0, "R10 irq view after write");

      // R12: writes that decode to nothing
      wr_reg(13'h0200, 32'h0000_0081);
      rd_reg(13'h0200, 32'h0, "R12 stray address reads zero");
      wr_reg(13'h0101, 32'h0000_0081);
      rd_reg(13'h0100, 32'h0000_0007, "R12 misaligned write dropped");
      wr_reg(13'h1140, 32'h0000_0081);
      rd_reg(13'h1140, 32'h0, "R12 line beyond count reads zero");
      rd_reg(13'h1100, 32'h0000_008A, "R12 line 64 untouched");
      settle();
      chk("R12 unaligned word untouched", 128'(ch_unaligned), 128'(32'h8000_0001));

      finish_run();
   end

endmodule